// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transmitter

This block turns parallel words into frames on a single asynchronous transmit line. Each frame's shape is chosen per word at run time: the number of data bits (5 to 9), the parity kind (none, even or odd), the number of stop bits (one or two), and the bit period in clock cycles. The host offers a word together with its frame settings on a valid/ready handshake. The block then drives the line waveform and a busy flag until the frame ends.

The line rests high. A frame is a single low start bit, then the data bits with the least significant bit first, then an optional parity bit, then the high stop bits. An internal divisor counter makes one enable tick per bit period. The counter restarts whenever a word is accepted. All settings are captured at acceptance. A new word can be taken in the last clock of the final stop bit, so frames follow each other with no idle gap.

Top module: `cfg_uart_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx_o` is 1, `ready_o` is 1 and `busy_o` is 0.
- R2: A word is taken on a clock edge where `valid_i` and `ready_o` are both 1. From the next cycle, `tx_o` is 0 for exactly one bit period (the start bit).
- R3: After the start bit, the data bits follow least significant bit first. Their count comes from `len_i`, where codes 5 to 9 mean that many bits. Codes below 5 are treated as 5 and codes above 9 as 9.
- R4: `parity_i` = 2'b01 adds an even parity bit, which makes the ones in data plus parity even. For example, data 0x5D with 8 bits gives a parity bit of 1. `parity_i` = 2'b10 adds the odd parity bit, which is 0 for that same data. Codes 2'b00 and 2'b11 add no parity bit. The parity bit comes directly after the last data bit.
- R5: The frame ends with one high stop bit when `stop2_i` = 0, and two when `stop2_i` = 1.
- R6: Every bit of a frame lasts `divisor_i` clock cycles, with a divisor of 0 treated as 1. Bit timing restarts at each acceptance.
- R7: Data and frame settings are sampled at acceptance. Changes to `data_i`, `len_i`, `parity_i`, `stop2_i` or `divisor_i` during a frame do not alter that frame.
- R8: `ready_o` is 0 from the cycle after acceptance until the final clock cycle of the last stop bit. In that final cycle `ready_o` is 1, so a waiting word starts its start bit with no idle cycle between frames. `busy_o` is 1 exactly while a frame occupies the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Host offers a word |
| ready_o | output | 1 | Block can take a word this cycle |
| data_i | input | MAX_LEN (9) | Data word; only the low bits selected by the length are sent |
| len_i | input | 4 | Data bit count code |
| parity_i | input | 2 | Parity kind: 01 even, 10 odd, 00/11 none |
| stop2_i | input | 1 | 1 selects two stop bits |
| divisor_i | input | DIV_W (16) | Clock cycles per bit |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A frame is on the line |

## Verification
The assertions assume that the host holds `valid_i` and the word steady only where the handshake defines them, and that reset is applied before the first word. They do not assume any relation between the frame settings and the divisor. The bench keeps to this by changing inputs only on falling edges. It drives every length code, including the clamped ones, every parity code and both stop counts, with divisors of 0, 1 and larger. It also scrambles all inputs while a frame is running with `valid_i` low, and holds `valid_i` high across frame boundaries to exercise back-to-back acceptance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int LEN_W = 4;

   typedef enum logic [1:0] {
      PAR_NONE     = 2'b00,
      PAR_EVEN     = 2'b01,
      PAR_ODD      = 2'b10,
      PAR_NONE_ALT = 2'b11
   } par_e;

   function automatic logic par_active(input par_e p);
      return (p == PAR_EVEN) || (p == PAR_ODD);
   endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   if (DIV_W < 1) begin : g_bad_div
      $error("uart_tx_baud: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] eff;
   logic             at_end;

   always_comb begin
      eff    = (div_i == '0) ? DIV_W'(1) : div_i;
      at_end = (cnt_q == eff - DIV_W'(1));
   end

   assign tick_o = run_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         if (at_end) cnt_q <= '0;
         else        cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R6
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q < eff));

   // R6
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int MIN_LEN   = 5,
   parameter int MAX_LEN   = 9,
   parameter bit PARITY_EN = 1'b1,
   localparam int FRAME_W  = MAX_LEN + 4,
   localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
   input  logic [MAX_LEN-1:0] data_i,
   input  logic [LEN_W-1:0]   len_i,
   input  par_e               par_i,
   input  logic               stop2_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [CNT_W-1:0]   nbits_o
);

   int          len_eff;
   logic        has_par;
   logic        par_bit;
   logic [MAX_LEN-1:0] mask;

   always_comb begin
      if (int'(len_i) < MIN_LEN)      len_eff = MIN_LEN;
      else if (int'(len_i) > MAX_LEN) len_eff = MAX_LEN;
      else                            len_eff = int'(len_i);
      for (int i = 0; i < MAX_LEN; i++) begin
         mask[i] = (i < len_eff);
      end
   end

   if (PARITY_EN) begin : g_par
      always_comb begin
         has_par = par_active(par_i);
         par_bit = (^(data_i & mask)) ^ (par_i == PAR_ODD);
      end
   end else begin : g_nopar
      always_comb begin
         has_par = 1'b0;
         par_bit = 1'b0;
      end
   end

   always_comb begin
      frame_o    = '1;
      frame_o[0] = 1'b0;
      for (int i = 0; i < MAX_LEN; i++) begin
         if (mask[i]) frame_o[1+i] = data_i[i];
      end
      if (has_par) frame_o[1+len_eff] = par_bit;
      nbits_o = CNT_W'(1 + len_eff + (has_par ? 1 : 0) + (stop2_i ? 2 : 1));
   end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
   parameter int FRAME_W = 13,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [CNT_W-1:0]   nbits_i,
   input  logic               tick_i,
   output logic               tx_o,
   output logic               busy_o,
   output logic               last_o
);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   rem_q;
   logic               busy_q;
   logic               tx_q;

   assign last_o = busy_q && (rem_q == CNT_W'(1));
   assign tx_o   = tx_q;
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         rem_q  <= '0;
         busy_q <= 1'b0;
         tx_q   <= 1'b1;
      end else if (accept_i) begin
         sh_q   <= frame_i;
         rem_q  <= nbits_i;
         busy_q <= 1'b1;
         tx_q   <= frame_i[0];
      end else if (busy_q && tick_i) begin
         if (last_o) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            tx_q   <= 1'b1;
            sh_q   <= '1;
         end else begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            tx_q  <= sh_q[1];
            rem_q <= rem_q - CNT_W'(1);
         end
      end
   end

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> tx_q);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_i |=> (!tx_q && busy_q));

   // R5
   last_is_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> tx_q);

   // R6
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !accept_i) |=> $stable(tx_q));

   // R8
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= CNT_W'(FRAME_W));

endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
   import uart_tx_pkg::*;
#(
   parameter int MIN_LEN   = 5,
   parameter int MAX_LEN   = 9,
   parameter int DIV_W     = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   output logic               ready_o,
   input  logic [MAX_LEN-1:0] data_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic [1:0]         parity_i,
   input  logic               stop2_i,
   input  logic [DIV_W-1:0]   divisor_i,
   output logic               tx_o,
   output logic               busy_o
);

   localparam int FRAME_W = MAX_LEN + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (MIN_LEN < 1 || MAX_LEN < MIN_LEN || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("cfg_uart_tx: length range does not fit the length code");
   end

   logic               accept;
   logic               tick;
   logic               last;
   logic               busy;
   logic [DIV_W-1:0]   div_q;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;

   assign ready_o = !busy || (last && tick);
   assign accept  = valid_i && ready_o;
   assign busy_o  = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= DIV_W'(1);
      else if (accept) div_q <= divisor_i;
   end

   uart_tx_framer #(
      .MIN_LEN  (MIN_LEN),
      .MAX_LEN  (MAX_LEN),
      .PARITY_EN(PARITY_EN)
   ) u_framer (
      .data_i (data_i),
      .len_i  (len_i),
      .par_i  (par_e'(parity_i)),
      .stop2_i(stop2_i),
      .frame_o(frame),
      .nbits_o(nbits)
   );

   uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(accept),
      .run_i    (busy),
      .div_i    (div_q),
      .tick_o   (tick)
   );

   uart_tx_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .frame_i (frame),
      .nbits_i (nbits),
      .tick_i  (tick),
      .tx_o    (tx_o),
      .busy_o  (busy),
      .last_o  (last)
   );

   // R7
   div_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept) |=> $stable(div_q));

   // R8
   ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_o && !ready_o));

   // R8
   ready_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |-> !ready_o);

endmodule

// File: tb/cfg_uart_tx_bench.sv
module cfg_uart_tx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [8:0]  data = '0;
   logic [3:0]  len = 4'd8;
   logic [1:0]  par = 2'b00;
   logic        stop2 = 1'b0;
   logic [15:0] div = 16'd1;
   logic        ready, tx, busy;

   int errors = 0;
   int checks = 0;
   int acc_cnt = 0;
   string phase = "R1";

   int  q_bit[$];
   int  q_kind[$];
   int  hold = 0;
   int  reload = 1;
   bit  m_busy = 0;

   always #10 clk = ~clk;

   cfg_uart_tx u_cfg_uart_tx (
      .clk(clk), .rst_n(rst_n), .valid_i(valid), .ready_o(ready),
      .data_i(data), .len_i(len), .parity_i(par), .stop2_i(stop2),
      .divisor_i(div), .tx_o(tx), .busy_o(busy)
   );

   function automatic bit m_ready();
      return !m_busy || (q_bit.size() == 1 && hold == 1);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (%s) at %0t: actual=%0d expected=%0d", req, phase, $time, act, exp);
      end
   endtask

   // behavioural reference: queue of bit levels, each held for reload cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         q_bit.delete(); q_kind.delete(); m_busy = 0; hold = 0;
      end else begin
         bit acc;
         acc = valid && m_ready();
         if (m_busy) begin
            hold--;
            if (hold == 0) begin
               void'(q_bit.pop_front()); void'(q_kind.pop_front());
               hold = reload;
               if (q_bit.size() == 0) m_busy = 0;
            end
         end
         if (acc) begin
            int l;
            int ones;
            l = (len < 5) ? 5 : (len > 9) ? 9 : int'(len);
            q_bit.push_back(0); q_kind.push_back(2);
            ones = 0;
            for (int i = 0; i < l; i++) begin
               q_bit.push_back(int'(data[i])); q_kind.push_back(3);
               ones += int'(data[i]);
            end
            if (par == 2'b01) begin q_bit.push_back(ones % 2); q_kind.push_back(4); end
            if (par == 2'b10) begin q_bit.push_back(1 - ones % 2); q_kind.push_back(4); end
            q_bit.push_back(1); q_kind.push_back(5);
            if (stop2) begin q_bit.push_back(1); q_kind.push_back(5); end
            reload = (div == 0) ? 1 : int'(div);
            hold = reload;
            m_busy = 1;
            acc_cnt++;
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_busy) begin
            case (q_kind[0])
               2: check("R2", int'(tx), q_bit[0]);
               3: check("R3", int'(tx), q_bit[0]);
               4: check("R4", int'(tx), q_bit[0]);
               default: check("R5", int'(tx), q_bit[0]);
            endcase
         end else begin
            check("R1", int'(tx), 1);
         end
         check("R8", int'(ready), int'(m_ready()));
         check("R8", int'(busy), int'(m_busy));
      end
   end

   task automatic send(input logic [8:0] d, input logic [3:0] l, input logic [1:0] p,
                       input logic s, input logic [15:0] dv, input bit keep);
      int c;
      data = d; len = l; par = p; stop2 = s; div = dv; valid = 1'b1;
      c = acc_cnt;
      while (acc_cnt == c) @(negedge clk);
      if (!keep) begin
         valid = 1'b0;
         data = 9'($urandom); len = 4'($urandom); par = 2'($urandom);
         stop2 = 1'($urandom); div = 16'($urandom_range(0, 7));
      end
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", int'(tx), 1);
      check("R1", int'(ready), 1);
      check("R1", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      phase = "R4 even example";
      send(9'h05D, 4'd8, 2'b01, 1'b0, 16'd4, 0); wait_idle();
      phase = "R4 odd example";
      send(9'h05D, 4'd8, 2'b10, 1'b0, 16'd4, 0); wait_idle();
      phase = "R5 two stops, R6 divisor 1";
      send(9'h013, 4'd5, 2'b00, 1'b1, 16'd1, 0); wait_idle();
      phase = "R3 nine bits";
      send(9'h1A5, 4'd9, 2'b01, 1'b1, 16'd3, 0); wait_idle();
      phase = "R3 clamp low, R6 divisor 0";
      send(9'h1FF, 4'd2, 2'b10, 1'b0, 16'd0, 0); wait_idle();
      phase = "R3 clamp high, R4 code 11";
      send(9'h155, 4'd15, 2'b11, 1'b1, 16'd2, 0); wait_idle();

      phase = "R8 back-to-back";
      for (int i = 0; i < 4; i++)
         send(9'($urandom), 4'(5 + i), 2'(i), 1'(i), 16'd5, (i != 3));
      wait_idle();

      phase = "R7 random with scrambling";
      for (int i = 0; i < 40; i++) begin
         send(9'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
              16'($urandom_range(0, 6)), ($urandom_range(0, 2) == 0));
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      valid = 1'b0;
      wait_idle();
      check("R1", int'(tx), 1);
      check("R1", int'(ready), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule